// File: doc/BRIEF.md
# Character Ring Queue with Overflow Tally

This block sits between a quick character producer and a slower consumer and absorbs bursts. The producer offers one byte per cycle on the put side, the way a receive interrupt routine hands over keystrokes. The consumer pulls bytes on the get side whenever it is ready to drain them. Storage is a fixed circular array addressed by a read index, which marks the oldest stored byte, and a write index, which marks the next free slot.

One slot is always left unused. This lets index equality mean "empty" and "write index one step behind the read index" mean "full", without a separate occupancy counter. A byte that arrives when no slot is free is thrown away. Each discarded byte adds one to a 16-bit saturating tally. A dedicated input clears the tally.

Top module: `char_ring_queue`

## Requirements
- R1: After reset, isEmpty is 1, isFull is 0, getValid is 0, getData is 0 and dropCount is 0.
- R2: Bytes leave in the order they were accepted. A get strobe on a non-empty queue puts the oldest byte on getData and raises getValid for exactly one cycle, both on the clock edge after the strobe.
- R3: isEmpty is 1 exactly when no bytes are stored, which is when the two indices are equal.
- R4: isFull is 1 exactly when DEPTH-1 bytes are stored (15 with the default DEPTH of 16).
- R5: A put without a get while isFull is 1 is discarded. The queue contents stay unchanged and dropCount rises by one.
- R6: A put together with a get while isFull is 1 does the get first and then stores the new byte. No drop is counted and isFull stays 1.
- R7: A get while isEmpty is 1 is ignored: getValid stays 0 and nothing is consumed. A put in the same cycle is still stored.
- R8: dropCount saturates at 65535 and does not wrap.
- R9: dropClear sets dropCount to 0 on the next edge. It wins over a drop in the same cycle.
- R10: Both indices wrap from DEPTH-1 to 0, so ordering and flags stay correct over any number of operations. DEPTH must be a power of two.
- R11: getData holds its last value in every cycle without an accepted get.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| putValid | input | 1 | Offer putData to the queue this cycle |
| putData | input | DATA_W | Byte offered by the producer |
| getStrobe | input | 1 | Request the oldest byte |
| dropClear | input | 1 | Zero the drop tally |
| getData | output | DATA_W | Registered byte from the last accepted get |
| getValid | output | 1 | getData was loaded on the last edge |
| isEmpty | output | 1 | No bytes stored |
| isFull | output | 1 | DEPTH-1 bytes stored |
| dropCount | output | DROP_W | Saturating count of discarded bytes |

## Verification
The properties assume that putValid, getStrobe and dropClear are always 0 or 1 and are sampled only at the rising edge. They also assume that putData is a known value whenever putValid is high. The bench meets these assumptions by changing every input only on the falling edge and always driving known values. It mixes random bursts, in which put and get probabilities vary from phase to phase, with directed cases at the full and empty boundaries and a long overflow run that drives the tally to saturation.

// File: rtl/crq_pkg.sv
package crq_pkg;
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic dropEn;
  } crq_strobe_t;
endpackage

// File: rtl/crq_ctrl.sv
module crq_ctrl
  import crq_pkg::*;
#(
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              putValid,
  input  logic              getStrobe,
  input  logic              dropClear,
  input  logic              isEmpty,
  input  logic              isFull,
  output crq_strobe_t       strobe,
  output logic [DROP_W-1:0] dropCount
);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  // A get is served first, so a full queue frees a slot for a simultaneous put (R6).
  always_comb begin
    strobe.rdEn   = getStrobe && !isEmpty;
    strobe.wrEn   = putValid && (!isFull || strobe.rdEn);
    strobe.dropEn = putValid && isFull && !strobe.rdEn;
  end

  // Saturating tally of discarded bytes; clear has priority (R8, R9).
  always_ff @(posedge clk) begin
    if (!rstN || dropClear) begin
      dropCount <= '0;
    end else if (strobe.dropEn && dropCount != DROP_MAX) begin
      dropCount <= dropCount + 1'b1;
    end
  end
endmodule

// File: rtl/crq_datapath.sv
module crq_datapath
  import crq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  crq_strobe_t       strobe,
  input  logic [DATA_W-1:0] putData,
  output logic [DATA_W-1:0] getData,
  output logic              getValid,
  output logic              isEmpty,
  output logic              isFull
);
  localparam int ADDR_W = $clog2(DEPTH);

  generate
    if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depthCheck
      $error("DEPTH must be a power of two of at least 2");
    end
  endgenerate

  logic [DATA_W-1:0] storage [DEPTH];
  logic [ADDR_W-1:0] headIdx;
  logic [ADDR_W-1:0] tailIdx;
  logic [ADDR_W-1:0] tailNext;

  // Power-of-two depth lets the index wrap by natural overflow (R10).
  assign tailNext = tailIdx + 1'b1;
  assign isEmpty  = (headIdx == tailIdx);
  assign isFull   = (headIdx == tailNext);

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      storage[tailIdx] <= putData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx  <= '0;
      tailIdx  <= '0;
      getData  <= '0;
      getValid <= 1'b0;
    end else begin
      getValid <= strobe.rdEn;
      if (strobe.wrEn) begin
        tailIdx <= tailNext;
      end
      if (strobe.rdEn) begin
        getData <= storage[headIdx];
        headIdx <= headIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/char_ring_queue.sv
module char_ring_queue
  import crq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              putValid,
  input  logic [DATA_W-1:0] putData,
  input  logic              getStrobe,
  input  logic              dropClear,
  output logic [DATA_W-1:0] getData,
  output logic              getValid,
  output logic              isEmpty,
  output logic              isFull,
  output logic [DROP_W-1:0] dropCount
);
  crq_strobe_t strobe;

  crq_ctrl #(.DROP_W(DROP_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .putValid  (putValid),
    .getStrobe (getStrobe),
    .dropClear (dropClear),
    .isEmpty   (isEmpty),
    .isFull    (isFull),
    .strobe    (strobe),
    .dropCount (dropCount)
  );

  crq_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .putData  (putData),
    .getData  (getData),
    .getValid (getValid),
    .isEmpty  (isEmpty),
    .isFull   (isFull)
  );
endmodule

// File: rtl/crq_checker.sv
module crq_checker #(
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              putValid,
  input logic              getStrobe,
  input logic              dropClear,
  input logic              isEmpty,
  input logic              isFull,
  input logic              getValid,
  input logic [DROP_W-1:0] dropCount
);
  localparam logic [DROP_W-1:0] MAX_CNT = '1;

  // R3
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(isEmpty && isFull));

  // R2
  get_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (getStrobe && !isEmpty) |=> getValid);

  // R5
  drop_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (putValid && isFull && !getStrobe && !dropClear && dropCount != MAX_CNT)
    |=> (dropCount == $past(dropCount) + 1'b1) && isFull);

  // R6
  full_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (putValid && getStrobe && isFull && !dropClear)
    |=> isFull && $stable(dropCount));

  // R7
  empty_get_chk: assert property (@(posedge clk) disable iff (!rstN)
    (getStrobe && isEmpty && !putValid) |=> isEmpty && !getValid);

  // R8
  drop_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount == MAX_CNT && !dropClear) |=> dropCount == MAX_CNT);

  // R9
  drop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    dropClear |=> dropCount == '0);
endmodule

bind char_ring_queue crq_checker #(.DROP_W(DROP_W)) u_chk (.*);

// File: tb/char_ring_queue_bench.sv
module char_ring_queue_bench;
  localparam int DEPTH = 16;
  localparam int CAP   = DEPTH - 1;
  localparam int MAXD  = 65535;

  logic       clk = 1'b0;
  logic       rstN;
  logic       putValid;
  logic [7:0] putData;
  logic       getStrobe;
  logic       dropClear;
  logic [7:0] getData;
  logic       getValid;
  logic       isEmpty;
  logic       isFull;
  logic [15:0] dropCount;

  int testsRun = 0;
  int testsFailed = 0;

  logic [7:0] mq [DEPTH];
  int mh = 0, mt = 0, mcnt = 0, mdrop = 0;
  logic [7:0] expData = 8'h00;
  logic expValid = 1'b0;
  string curReq = "R1";

  always #10 clk = ~clk;

  char_ring_queue u_char_ring_queue (
    .clk(clk), .rstN(rstN), .putValid(putValid), .putData(putData),
    .getStrobe(getStrobe), .dropClear(dropClear), .getData(getData),
    .getValid(getValid), .isEmpty(isEmpty), .isFull(isFull),
    .dropCount(dropCount)
  );

  task automatic check(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    check({curReq, " R3 isEmpty"}, int'(isEmpty), int'(mcnt == 0));
    check({curReq, " R4 isFull"}, int'(isFull), int'(mcnt == CAP));
    check({curReq, " R2 getValid"}, int'(getValid), int'(expValid));
    check({curReq, " R2/R11 getData"}, int'(getData), int'(expData));
    check({curReq, " dropCount"}, int'(dropCount), mdrop);
  endtask

  // Drive at falling edge, update the model, then compare at the next falling edge.
  task automatic doCycle(input logic p, input logic [7:0] d, input logic g, input logic c);
    logic rd, wr, dr;
    putValid = p; putData = d; getStrobe = g; dropClear = c;
    rd = g && (mcnt > 0);
    wr = p && ((mcnt < CAP) || rd);
    dr = p && !wr;
    expValid = rd;
    if (rd) begin
      expData = mq[mh];
      mh = (mh + 1) % DEPTH;
    end
    if (wr) begin
      mq[mt] = d;
      mt = (mt + 1) % DEPTH;
    end
    mcnt = mcnt + int'(wr) - int'(rd);
    if (c) mdrop = 0;
    else if (dr && mdrop < MAXD) mdrop++;
    @(negedge clk);
    checkAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; putValid = 1'b0; putData = 8'h00; getStrobe = 1'b0; dropClear = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    checkAll();

    // R7: get on empty, alone and together with a put
    curReq = "R7";
    doCycle(1'b0, 8'h00, 1'b1, 1'b0);
    doCycle(1'b1, 8'hA5, 1'b1, 1'b0);
    check("R7 put kept during empty get", int'(isEmpty), 0);
    curReq = "R2";
    doCycle(1'b0, 8'h00, 1'b1, 1'b0);
    check("R2 first byte out", int'(getData), 8'hA5);
    doCycle(1'b0, 8'h00, 1'b0, 1'b0);
    check("R11 data held", int'(getData), 8'hA5);

    // R4: fill to capacity
    curReq = "R4";
    for (int i = 0; i < CAP; i++) doCycle(1'b1, 8'(8'h10 + i), 1'b0, 1'b0);
    check("R4 full at DEPTH-1", int'(isFull), 1);

    // R5: overflow discarded and tallied
    curReq = "R5";
    doCycle(1'b1, 8'hEE, 1'b0, 1'b0);
    check("R5 one drop", int'(dropCount), 1);

    // R6: simultaneous put and get on full
    curReq = "R6";
    doCycle(1'b1, 8'h77, 1'b1, 1'b0);
    check("R6 no extra drop", int'(dropCount), 1);
    check("R6 oldest read", int'(getData), 8'h10);

    // R2: drain, order checked by model
    curReq = "R2";
    for (int i = 0; i < CAP + 2; i++) doCycle(1'b0, 8'h00, 1'b1, 1'b0);
    check("R2 last byte is swap byte", int'(getData), 8'h77);

    // R9: clear beats a simultaneous drop
    curReq = "R9";
    for (int i = 0; i < CAP; i++) doCycle(1'b1, 8'(i), 1'b0, 1'b0);
    doCycle(1'b1, 8'h55, 1'b0, 1'b1);
    check("R9 clear wins", int'(dropCount), 0);
    for (int i = 0; i < CAP; i++) doCycle(1'b0, 8'h00, 1'b1, 1'b0);

    // R10: random traffic over many wraps
    curReq = "R10";
    for (int ph = 0; ph < 20; ph++) begin
      int pp = int'($urandom % 5);
      int gp = int'($urandom % 5);
      for (int i = 0; i < 150; i++) begin
        doCycle(1'(int'($urandom % 4) < pp), 8'($urandom),
                1'(int'($urandom % 4) < gp), 1'($urandom % 64 == 0));
      end
    end

    // R8: saturation
    curReq = "R8";
    doCycle(1'b0, 8'h00, 1'b0, 1'b1);
    for (int i = 0; i < CAP; i++) doCycle(1'b1, 8'(i), 1'b0, 1'b0);
    for (int i = 0; i < MAXD + 5; i++) doCycle(1'b1, 8'hC3, 1'b0, 1'b0);
    check("R8 saturated", int'(dropCount), MAXD);
    curReq = "R9";
    doCycle(1'b0, 8'h00, 1'b0, 1'b1);
    check("R9 cleared after saturation", int'(dropCount), 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule